// File: doc/BRIEF.md
# Multiple-Register Memory Transfer Sequencer

This block moves data between a 256-entry file of 64-bit registers and a word-wide memory. One start pulse launches a whole transfer. In the two block modes it walks an inclusive range of register indices in ascending order. It issues one memory beat per register, and the address climbs by one 8-byte word per beat, starting from a base address. In the two masked modes it performs a single beat on one target register. An 8-bit byte select then decides which byte lanes move. On a masked load, the lanes that are not selected keep their old register contents.

The register file lives inside the block. Its contents become visible only through the memory write data of store transfers. The memory side is a request interface with a write flag, byte enables and a ready input. A beat stays on the bus until the memory accepts it. A one-cycle completion pulse ends every transfer, including one that moves nothing.

Top module: `xfer_seq`

## Requirements
- R1: After reset the block is idle (`busy_o`, `done_o`, `mem_req_o` low). Register 0 and registers 1..254 hold all zeros, and register 255 holds all ones.
- R2: `start_i` is taken only while `busy_o` is low. A start pulse that arrives while a transfer is running has no effect on that transfer's beats.
- R3: Mode codes are 0 = block load and 1 = block store. In these modes the registers `first_i`..`last_i` are transferred in ascending order, one beat each. The beat for register i uses address `base_i + 8*(i - first_i)`.
- R4: Block beats enable all 8 byte lanes (`mem_be_o` = 8'hFF). A block store drives the register's value on `mem_wdata_o`. A block load writes `mem_rdata_i` into the register.
- R5: In a block mode with `first_i > last_i`, `done_o` rises in the cycle after the start edge and no beat is issued.
- R6: While `mem_ready_i` is low, a pending beat holds its request, address, write flag, byte enables and write data. The sequencer moves on only in a cycle where ready is high.
- R7: Mode 3 (masked store) issues exactly one write beat at `base_i` for register `first_i`. The beat uses `mem_be_o = mask_i` and the full register value as write data. Bit k of the mask selects byte lane k, which is bits 8k+7..8k.
- R8: Mode 2 (masked load) issues exactly one read beat at `base_i` with `mem_be_o = mask_i`. Byte k of register `first_i` takes byte k of `mem_rdata_i` where mask bit k is set, and keeps its previous value where it is clear.
- R9: `done_o` is high for exactly one cycle. That cycle follows the edge at which the final beat is accepted, and no request is active during it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch a transfer (sampled when idle) |
| mode_i | input | 2 | 0 block load, 1 block store, 2 masked load, 3 masked store |
| first_i | input | 8 | First register index, or target register in masked modes |
| last_i | input | 8 | Last register index (block modes) |
| base_i | input | 64 | Starting memory byte address |
| mask_i | input | 8 | Byte-lane select for masked modes |
| busy_o | output | 1 | A transfer is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Memory beat request |
| mem_we_o | output | 1 | Beat is a write |
| mem_addr_o | output | 64 | Beat byte address |
| mem_be_o | output | 8 | Beat byte enables |
| mem_wdata_o | output | 64 | Write data |
| mem_rdata_i | input | 64 | Read data, valid with `mem_ready_i` |
| mem_ready_i | input | 1 | Memory accepts the current beat |

## Verification
The assertions assume that `mem_ready_i` matters only while a request is raised, and that `mem_rdata_i` is valid in the cycle ready is high. They also assume that mode and range inputs are steady while `start_i` is high. The stimulus drives ready and read data only against an active beat, and sometimes holds ready low for two cycles to exercise the stall path. All inputs change on the falling edge. The start pulse lasts exactly one cycle, apart from one deliberate extra pulse that is injected during a running transfer.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

    typedef enum logic [1:0] {
        MODE_BLK_LD = 2'd0,
        MODE_BLK_ST = 2'd1,
        MODE_MSK_LD = 2'd2,
        MODE_MSK_ST = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BEAT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/xfer_regfile.sv
module xfer_regfile #(
    parameter int unsigned NREGS = 256,
    parameter int unsigned DW    = 64,
    localparam int unsigned IDXW = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDXW-1:0] idx_i,
    output logic [DW-1:0]   rdata_o,
    input  logic            we_i,
    input  logic [DW-1:0]   wdata_i
);

    logic [DW-1:0] regs_q [NREGS];

    assign rdata_o = regs_q[idx_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) begin
                regs_q[i] <= (i == NREGS - 1) ? {DW{1'b1}} : {DW{1'b0}};
            end
        end else if (we_i) begin
            regs_q[idx_i] <= wdata_i;
        end
    end

endmodule

// File: rtl/xfer_ctrl.sv
module xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int unsigned NREGS = 256,
    parameter int unsigned DW    = 64,
    parameter int unsigned AW    = 64,
    localparam int unsigned IDXW  = $clog2(NREGS),
    localparam int unsigned NBYTE = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [IDXW-1:0]  first_i,
    input  logic [IDXW-1:0]  last_i,
    input  logic [AW-1:0]    base_i,
    input  logic [NBYTE-1:0] mask_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [IDXW-1:0]  rf_idx_o,
    input  logic [DW-1:0]    rf_rdata_i,
    output logic             rf_we_o,
    output logic [DW-1:0]    rf_wdata_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [NBYTE-1:0] mem_be_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_ready_i
);

    localparam logic [AW-1:0] ADDR_STEP = AW'(NBYTE);

    typedef struct packed {
        seq_state_e       st;
        xfer_mode_e       mode;
        logic [IDXW-1:0]  idx;
        logic [IDXW-1:0]  last;
        logic [AW-1:0]    addr;
        logic [NBYTE-1:0] mask;
    } seq_s;

    seq_s s_d, s_q;

    logic is_store, is_masked, beat_ok, last_beat;

    always_comb begin
        is_store  = s_q.mode[0];
        is_masked = s_q.mode[1];
        beat_ok   = (s_q.st == ST_BEAT) && mem_ready_i;
        last_beat = is_masked || (s_q.idx == s_q.last);

        s_d = s_q;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.mode = xfer_mode_e'(mode_i);
                    s_d.idx  = first_i;
                    s_d.last = last_i;
                    s_d.addr = base_i;
                    s_d.mask = mask_i;
                    s_d.st   = (!mode_i[1] && (first_i > last_i)) ? ST_DONE : ST_BEAT;
                end
            end
            ST_BEAT: begin
                if (mem_ready_i) begin
                    if (last_beat) begin
                        s_d.st = ST_DONE;
                    end else begin
                        s_d.idx  = s_q.idx + 1'b1;
                        s_d.addr = s_q.addr + ADDR_STEP;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // beat outputs
    assign busy_o      = (s_q.st != ST_IDLE);
    assign done_o      = (s_q.st == ST_DONE);
    assign mem_req_o   = (s_q.st == ST_BEAT);
    assign mem_we_o    = is_store;
    assign mem_addr_o  = s_q.addr;
    assign mem_be_o    = is_masked ? s_q.mask : {NBYTE{1'b1}};
    assign mem_wdata_o = rf_rdata_i;
    assign rf_idx_o    = s_q.idx;
    assign rf_we_o     = beat_ok && !is_store;

    // per-lane merge of returned data into the old register value
    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        assign rf_wdata_o[8*b +: 8] = mem_be_o[b] ? mem_rdata_i[8*b +: 8]
                                                  : rf_rdata_i[8*b +: 8];
    end

    p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_ok && !is_masked && (s_q.idx != s_q.last))
        |=> (mem_req_o && (mem_addr_o == $past(mem_addr_o) + ADDR_STEP)));

    p_hold_beat_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i)
        |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_be_o)));

    p_empty_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !mode_i[1] && (first_i > last_i)) |=> (done_o && !mem_req_o));

    p_busy_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && mem_req_o && !mem_ready_i) |=> $stable(mem_addr_o));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
    import xfer_pkg::*;
#(
    parameter int unsigned NREGS = 256,
    parameter int unsigned DW    = 64,
    parameter int unsigned AW    = 64,
    localparam int unsigned IDXW  = $clog2(NREGS),
    localparam int unsigned NBYTE = DW / 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [1:0]       mode_i,
    input  logic [IDXW-1:0]  first_i,
    input  logic [IDXW-1:0]  last_i,
    input  logic [AW-1:0]    base_i,
    input  logic [NBYTE-1:0] mask_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [AW-1:0]    mem_addr_o,
    output logic [NBYTE-1:0] mem_be_o,
    output logic [DW-1:0]    mem_wdata_o,
    input  logic [DW-1:0]    mem_rdata_i,
    input  logic             mem_ready_i
);

    logic [IDXW-1:0] rf_idx;
    logic [DW-1:0]   rf_rdata, rf_wdata;
    logic            rf_we;

    xfer_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx_i   (rf_idx),
        .rdata_o (rf_rdata),
        .we_i    (rf_we),
        .wdata_i (rf_wdata)
    );

    xfer_ctrl #(.NREGS(NREGS), .DW(DW), .AW(AW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .first_i     (first_i),
        .last_i      (last_i),
        .base_i      (base_i),
        .mask_i      (mask_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .rf_idx_o    (rf_idx),
        .rf_rdata_i  (rf_rdata),
        .rf_we_o     (rf_we),
        .rf_wdata_o  (rf_wdata),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_be_o    (mem_be_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .mem_ready_i (mem_ready_i)
    );

endmodule

// File: tb/xfer_seq_tb_top.sv
module xfer_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [1:0]  mode_i;
    logic [7:0]  first_i, last_i;
    logic [63:0] base_i;
    logic [7:0]  mask_i;
    logic        busy_o, done_o, mem_req_o, mem_we_o;
    logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
    logic [7:0]  mem_be_o;
    logic        mem_ready_i;

    always #5 clk = ~clk;

    xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .first_i(first_i), .last_i(last_i), .base_i(base_i), .mask_i(mask_i),
        .busy_o(busy_o), .done_o(done_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
        .mem_rdata_i(mem_rdata_i), .mem_ready_i(mem_ready_i)
    );

    typedef struct {
        int          idx;
        logic [63:0] addr;
        bit          we;
        logic [7:0]  be;
    } beat_t;

    logic [63:0] rf_m [256];
    logic [63:0] mem_m [logic [63:0]];
    beat_t       q [$];
    int          total = 0;
    int          bad   = 0;
    bit          finished = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mem_rd(input logic [63:0] a);
        return mem_m.exists(a) ? mem_m[a] : 64'h0;
    endfunction

    function automatic logic [63:0] merge(input logic [63:0] old, input logic [63:0] nw, input logic [7:0] be);
        logic [63:0] r = old;
        for (int b = 0; b < 8; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    // Drives one transfer and checks it cycle by cycle against the model
    task automatic run_op(input int mode, input int first, input int last, input logic [63:0] base,
                          input logic [7:0] mask, input bit slow, input bit inject);
        int cyc = 0;
        q.delete();
        if (mode >= 2) begin
            q.push_back('{first, base, mode == 3, mask});
        end else begin
            for (int i = first; i <= last; i++)
                q.push_back('{i, base + 64'(8 * (i - first)), mode == 1, 8'hFF});
        end
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'(mode); first_i = 8'(first); last_i = 8'(last);
        base_i = base; mask_i = mask;
        @(negedge clk);
        start_i = 1'b0;
        while (1) begin
            if (q.size() > 0) begin
                chk(mem_req_o === 1'b1, "R3 request", 64'(mem_req_o), 64'h1);
                chk(mem_addr_o === q[0].addr, "R3 address", mem_addr_o, q[0].addr);
                chk(mem_we_o === q[0].we, "R7 write flag", 64'(mem_we_o), 64'(q[0].we));
                chk(mem_be_o === q[0].be, (mode >= 2) ? "R8 byte enables" : "R4 byte enables",
                    64'(mem_be_o), 64'(q[0].be));
                chk(done_o === 1'b0, "R9 early done", 64'(done_o), 64'h0);
                if (q[0].we)
                    chk(mem_wdata_o === rf_m[q[0].idx], "R4 write data", mem_wdata_o, rf_m[q[0].idx]);
                if (inject && cyc == 1) begin
                    start_i = 1'b1; mode_i = 2'd1; first_i = 8'd0; last_i = 8'd0;
                    base_i = 64'hDEAD_0000; mask_i = 8'h01;
                end else begin
                    start_i = 1'b0;
                end
                mem_ready_i = slow ? ((cyc % 3) == 2) : 1'b1;
                mem_rdata_i = mem_rd(q[0].addr);
                if (mem_ready_i) begin
                    if (q[0].we) mem_m[q[0].addr] = merge(mem_rd(q[0].addr), mem_wdata_o, q[0].be);
                    else         rf_m[q[0].idx]   = merge(rf_m[q[0].idx], mem_rdata_i, q[0].be);
                    void'(q.pop_front());
                end
                cyc++;
                @(negedge clk);
                mem_ready_i = 1'b0;
                start_i = 1'b0;
            end else begin
                chk(done_o === 1'b1, "R9 done pulse", 64'(done_o), 64'h1);
                chk(mem_req_o === 1'b0, "R5 no beat at done", 64'(mem_req_o), 64'h0);
                break;
            end
        end
        @(negedge clk);
        chk(done_o === 1'b0, "R9 done single cycle", 64'(done_o), 64'h0);
        chk(busy_o === 1'b0, "R2 idle after transfer", 64'(busy_o), 64'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) rf_m[i] = (i == 255) ? '1 : '0;
        rst_n = 1'b0; start_i = 1'b0; mode_i = '0; first_i = '0; last_i = '0;
        base_i = '0; mask_i = '0; mem_rdata_i = '0; mem_ready_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle outputs after reset
        chk(busy_o === 1'b0, "R1 busy", 64'(busy_o), 64'h0);
        chk(done_o === 1'b0, "R1 done", 64'(done_o), 64'h0);
        chk(mem_req_o === 1'b0, "R1 req", 64'(mem_req_o), 64'h0);

        // R1 reset contents seen through block stores at both ends
        run_op(1, 0, 3, 64'h1000, 8'h00, 0, 0);
        run_op(1, 252, 255, 64'h2000, 8'h00, 1, 0);

        // R3 R4 block load with stalls, then store back
        for (int k = 0; k < 8; k++) mem_m[64'h3000 + 64'(8 * k)] = 64'h0123_4567_89AB_CDEF ^ (64'(k) << 40) ^ 64'(k * 17);
        run_op(0, 10, 17, 64'h3000, 8'h00, 1, 0);
        run_op(1, 10, 17, 64'h4000, 8'h00, 0, 0);

        // R5 empty range in both block modes
        run_op(0, 9, 8, 64'h5000, 8'h00, 0, 0);
        run_op(1, 200, 3, 64'h5000, 8'h00, 0, 0);

        // R8 masked load into low lanes, other lanes kept
        mem_m[64'h6000] = 64'hA1A2_A3A4_A5A6_A7A8;
        run_op(2, 12, 0, 64'h6000, 8'h0F, 1, 0);
        run_op(1, 12, 12, 64'h6100, 8'h00, 0, 0);
        // R8 empty mask leaves register untouched
        run_op(2, 13, 0, 64'h6000, 8'h00, 0, 0);
        run_op(1, 13, 13, 64'h6200, 8'h00, 0, 0);

        // R7 masked store of upper lanes of all-ones register
        run_op(3, 255, 0, 64'h7000, 8'hF0, 0, 0);
        chk(mem_rd(64'h7000) === 64'hFFFF_FFFF_0000_0000, "R7 stored lanes",
            mem_rd(64'h7000), 64'hFFFF_FFFF_0000_0000);

        // R2 start pulse during a running transfer has no effect
        run_op(1, 14, 17, 64'h8000, 8'h00, 1, 1);

        // R3 range ending at the top index, single-register range
        for (int k = 0; k < 2; k++) mem_m[64'h9000 + 64'(8 * k)] = 64'h5555_0000_0000_0000 + 64'(k);
        run_op(0, 254, 255, 64'h9000, 8'h00, 0, 0);
        run_op(1, 254, 255, 64'h9100, 8'h00, 1, 0);
        run_op(1, 0, 0, 64'h9200, 8'h00, 0, 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule